// File: doc/BRIEF.md
# Standby Wake-Up Stabilization Timer

This block controls the exit from a low-power standby state. Software programs a byte-wide control register over a small register bus. The register holds a standby-select bit, a 3-bit wait-length code and a bus-output policy bit. When the CPU issues a sleep command while standby-select is set, the block drops the CPU clock-enable. A later wake interrupt starts a settling counter. The clock-enable stays low until the counter has run the programmed number of clock states, so the oscillator has time to settle. The block then raises clock-enable again and gives a one-cycle ready pulse.

The policy bit decides how the address bus and bus strobes behave while the clock is stopped. They either keep their last driven value through a hold signal, or they lose their output enable and go to high impedance. The output enable comes back in the same cycle as the clock-enable. A read-only status register holds a sticky flag. The flag is set when software writes the prohibited wait code, and software clears it by writing a one to it.

The base wait length is a parameter. Its default of 2^13 states gives wait lengths from 8192 up to 262144 states.

Top module: `stby_wake_ctrl`

## Requirements
- R1: After reset, the control register at address 0 reads 0x08, the status register at address 1 reads 0x00, clk_en and bus_oe are 1, and bus_hold and wake_ready are 0.
- R2: In the control register, bit 7 is standby-select, bits 6:4 are the wait code and bit 3 is the output-policy bit, and all three are read/write. Bits 2:0 always read 0, and writing them has no effect.
- R3: Wait codes 0 to 5 give a wait of 2^BASE_LOG2 × 2^code clock states. This is the number of cycles from the wake sample to clk_en returning high, and clk_en stays 0 for that whole time.
- R4: The reserved code 6 gives the longest valid wait, 2^(BASE_LOG2+5) states.
- R5: The prohibited code 7 gives a wait of 16 states. Writing code 7 sets status bit 0, which stays set until software writes address 1 with bit 0 = 1.
- R6: While running, a sleep_cmd with standby-select set enters standby. From the next cycle clk_en is 0 and in_standby is 1. With standby-select clear, sleep_cmd is ignored.
- R7: While the clock is stopped (standby or wait), a policy bit of 1 gives bus_oe = 1 and bus_hold = 1, and a policy bit of 0 gives bus_oe = 0 and bus_hold = 0. While running, bus_oe = 1 and bus_hold = 0.
- R8: wake_ready is high for exactly one cycle, which is the first cycle in which clk_en is high again. bus_oe is 1 in that same cycle.
- R9: During the wait, sleep_cmd and further wake_irq pulses are ignored. They neither restart nor lengthen the count, and the block returns to running.
- R10: While running, wake_irq has no effect.
- R11: The wait length is taken from the code at the moment the wake is sampled. Rewriting the code during the wait does not change the current wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 1 | 0 = control register, 1 = status register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sleep_cmd | input | 1 | CPU request to enter standby |
| wake_irq | input | 1 | Interrupt that cancels standby |
| clk_en | output | 1 | CPU clock enable |
| wake_ready | output | 1 | One-cycle pulse when the clock restarts |
| in_standby | output | 1 | High while standby waits for a wake |
| bus_oe | output | 1 | Output enable for the address bus and strobes |
| bus_hold | output | 1 | Hold the bus outputs at their last value |

## Verification
The assertions assume that wake_irq and sleep_cmd are synchronous to clk and are sampled only on rising edges. They also assume that BASE_LOG2 plus 5 fits the counter, so the terminal value is always reachable.

The bench drives every input at the falling edge, so each input is stable for one whole cycle. It runs the block with a reduced BASE_LOG2 of 5, which keeps the longest wait at 1024 cycles. It never asserts sleep_cmd and wake_irq in the last cycle of a wait. This keeps every measured wait length unambiguous.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STBY = 2'd1,
    ST_WAKE = 2'd2
  } stby_state_e;

  localparam int REG_W       = 8;
  localparam int CODE_W      = 3;
  localparam int SSBY_BIT    = 7;
  localparam int CODE_LO     = 4;
  localparam int OPE_BIT     = 3;
  localparam int FLAG_BIT    = 0;
  localparam logic [CODE_W-1:0] CODE_PROHIB = 3'b111;

  function automatic logic is_prohibited(input logic [CODE_W-1:0] code);
    return code == CODE_PROHIB;
  endfunction

  // Wait length in clock states for a given code.
  function automatic logic [31:0] delay_states(input logic [CODE_W-1:0] code,
                                               input int unsigned base_log2,
                                               input int unsigned max_code,
                                               input int unsigned prohib_log2);
    logic [31:0] one;
    one = 32'd1;
    if (is_prohibited(code))
      return one << prohib_log2;
    else if (32'(code) > max_code)
      return one << (base_log2 + max_code);
    else
      return one << (base_log2 + 32'(code));
  endfunction

endpackage

// File: rtl/stby_ctrl_regs.sv
module stby_ctrl_regs
  import stby_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              ssby,
  output logic [CODE_W-1:0] dly_code,
  output logic              ope,
  output logic              prohib_flag,
  output logic              ev_flag_clr
);

  logic ssby_q, ope_q, flag_q;
  logic [CODE_W-1:0] code_q;
  logic wr_ctrl, wr_stat;
  logic [CODE_W-1:0] code_in;
  logic [1:0] wdata_unused;

  assign wr_ctrl      = bus_sel && bus_wr && !bus_addr;
  assign wr_stat      = bus_sel && bus_wr &&  bus_addr;
  assign code_in      = bus_wdata[CODE_LO +: CODE_W];
  assign ev_flag_clr  = wr_stat && bus_wdata[FLAG_BIT];
  assign wdata_unused = bus_wdata[2:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssby_q <= 1'b0;
      code_q <= '0;
      ope_q  <= 1'b1;
    end else if (wr_ctrl) begin
      ssby_q <= bus_wdata[SSBY_BIT];
      code_q <= code_in;
      ope_q  <= bus_wdata[OPE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (wr_ctrl && is_prohibited(code_in))
      flag_q <= 1'b1;
    else if (ev_flag_clr)
      flag_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) begin
      bus_rdata[FLAG_BIT] = flag_q;
    end else begin
      bus_rdata[SSBY_BIT]              = ssby_q;
      bus_rdata[CODE_LO +: CODE_W]     = code_q;
      bus_rdata[OPE_BIT]               = ope_q;
    end
  end

  assign ssby        = ssby_q;
  assign dly_code    = code_q;
  assign ope         = ope_q;
  assign prohib_flag = flag_q;

endmodule

// File: rtl/stby_delay_timer.sv
module stby_delay_timer
  import stby_pkg::*;
#(
  parameter int BASE_LOG2   = 13,
  parameter int MAX_CODE    = 5,
  parameter int PROHIB_LOG2 = 4,
  parameter int CNT_W       = BASE_LOG2 + MAX_CODE
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  output logic              busy,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  limit_m1,
  output logic              done
);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q, lim_q;
  logic [31:0]       len;

  assign len  = delay_states(code, BASE_LOG2, MAX_CODE, PROHIB_LOG2);
  assign done = busy_q && (cnt_q == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        lim_q  <= CNT_W'(len - 32'd1);
      end
    end else if (done) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy     = busy_q;
  assign cnt      = cnt_q;
  assign limit_m1 = lim_q;

endmodule

// File: rtl/stby_seq_fsm.sv
module stby_seq_fsm
  import stby_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_cmd,
  input  logic ssby,
  input  logic wake_irq,
  input  logic ope,
  input  logic tmr_done,
  output logic tmr_start,
  output logic clk_en,
  output logic wake_ready,
  output logic in_standby,
  output logic bus_oe,
  output logic bus_hold
);

  stby_state_e state_q, state_d;
  logic ready_q;
  logic low_pwr;

  always_comb begin
    state_d   = state_q;
    tmr_start = 1'b0;
    unique case (state_q)
      ST_RUN:  if (sleep_cmd && ssby) state_d = ST_STBY;
      ST_STBY: if (wake_irq) begin
                 state_d   = ST_WAKE;
                 tmr_start = 1'b1;
               end
      ST_WAKE: if (tmr_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ready_q <= (state_q == ST_WAKE) && tmr_done;
    end
  end

  assign low_pwr    = state_q != ST_RUN;
  assign clk_en     = !low_pwr;
  assign in_standby = state_q == ST_STBY;
  assign bus_oe     = !low_pwr || ope;
  assign bus_hold   = low_pwr && ope;
  assign wake_ready = ready_q;

endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int BASE_LOG2   = 13,
  parameter int MAX_CODE    = 5,
  parameter int PROHIB_LOG2 = 4
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sleep_cmd,
  input  logic       wake_irq,
  output logic       clk_en,
  output logic       wake_ready,
  output logic       in_standby,
  output logic       bus_oe,
  output logic       bus_hold
);

  localparam int CNT_W = BASE_LOG2 + MAX_CODE;

  logic              ssby, ope, prohib_flag, ev_flag_clr;
  logic [CODE_W-1:0] dly_code;
  logic              tmr_start, tmr_busy, tmr_done;
  logic [CNT_W-1:0]  tmr_cnt, tmr_limit_m1;

  stby_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ssby(ssby), .dly_code(dly_code), .ope(ope),
    .prohib_flag(prohib_flag), .ev_flag_clr(ev_flag_clr)
  );

  stby_delay_timer #(
    .BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE),
    .PROHIB_LOG2(PROHIB_LOG2), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(tmr_start), .code(dly_code),
    .busy(tmr_busy), .cnt(tmr_cnt), .limit_m1(tmr_limit_m1),
    .done(tmr_done)
  );

  stby_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sleep_cmd(sleep_cmd), .ssby(ssby), .wake_irq(wake_irq),
    .ope(ope), .tmr_done(tmr_done), .tmr_start(tmr_start),
    .clk_en(clk_en), .wake_ready(wake_ready), .in_standby(in_standby),
    .bus_oe(bus_oe), .bus_hold(bus_hold)
  );

endmodule

// File: rtl/stby_wake_chk.sv
module stby_wake_chk #(
  parameter int CNT_W = 18
)(
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             wake_ready,
  input logic             in_standby,
  input logic             bus_oe,
  input logic             bus_hold,
  input logic             bus_addr,
  input logic [7:0]       bus_rdata,
  input logic             tmr_busy,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic [CNT_W-1:0] tmr_limit_m1,
  input logic             prohib_flag,
  input logic             ev_flag_clr
);

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> bus_rdata[2:0] == 3'b000);                          // R2

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> tmr_cnt <= tmr_limit_m1);                            // R3

  AST_CLOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> !clk_en);                                            // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    prohib_flag && !ev_flag_clr |=> prohib_flag);                     // R5

  AST_STBY_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    in_standby |-> !clk_en);                                          // R6

  AST_OE_WHEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> bus_oe && !bus_hold);                                  // R7

  AST_HOLD_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hold |-> bus_oe);                                             // R7

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ready |=> !wake_ready);                                      // R8

  AST_READY_AT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ready |-> clk_en && !$past(clk_en));                         // R8

  AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy && $past(tmr_busy) |-> tmr_cnt == CNT_W'($past(tmr_cnt) + 1'b1)); // R9

  AST_LIMIT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy && $past(tmr_busy) |-> $stable(tmr_limit_m1));           // R11

endmodule

bind stby_wake_ctrl stby_wake_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wake_ready(wake_ready),
  .in_standby(in_standby), .bus_oe(bus_oe), .bus_hold(bus_hold),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tmr_busy(tmr_busy),
  .tmr_cnt(tmr_cnt), .tmr_limit_m1(tmr_limit_m1),
  .prohib_flag(prohib_flag), .ev_flag_clr(ev_flag_clr)
);

// File: tb/test_stby_wake_ctrl.sv
`timescale 1ns/1ps
module test_stby_wake_ctrl;

  localparam int TB_BASE = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sleep_cmd = 1'b0, wake_irq = 1'b0;
  logic       clk_en, wake_ready, in_standby, bus_oe, bus_hold;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  stby_wake_ctrl #(.BASE_LOG2(TB_BASE)) i_stby_wake_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sleep_cmd(sleep_cmd), .wake_irq(wake_irq),
    .clk_en(clk_en), .wake_ready(wake_ready), .in_standby(in_standby),
    .bus_oe(bus_oe), .bus_hold(bus_hold)
  );

  // Expected wait length, derived from the requirement text.
  function automatic int exp_len(input int code);
    if (code == 7) return 16;
    if (code == 6) return (1 << TB_BASE) * 32;
    return (1 << TB_BASE) * (1 << code);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic enter_standby();
    @(negedge clk);
    sleep_cmd = 1'b1;
    @(negedge clk);
    sleep_cmd = 1'b0;
  endtask

  // Pulse wake; count cycles with clk_en low. Optionally disturb mid-count.
  task automatic run_wake(input bit disturb, input bit rewrite,
                          input logic [7:0] new_ctrl,
                          output int len, output int oe_low_seen,
                          output int ready_ok);
    @(negedge clk);
    wake_irq = 1'b1;
    @(negedge clk);
    wake_irq = 1'b0;
    len = 0; oe_low_seen = 0;
    while (!clk_en && len < 5000) begin
      len++;
      if (!bus_oe) oe_low_seen++;
      if (disturb && len == 10) begin sleep_cmd = 1'b1; wake_irq = 1'b1; end
      if (disturb && len == 11) begin sleep_cmd = 1'b0; wake_irq = 1'b0; end
      if (rewrite && len == 12) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = new_ctrl;
      end
      if (rewrite && len == 13) begin bus_sel = 1'b0; bus_wr = 1'b0; end
      @(negedge clk);
    end
    ready_ok = (wake_ready == 1'b1 && bus_oe == 1'b1) ? 1 : 0;
    @(negedge clk);
    if (wake_ready) ready_ok = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_read(1'b0, d); chk("R1 ctrl reset", d, 8'h08);
    reg_read(1'b1, d); chk("R1 status reset", d, 8'h00);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 bus_oe", bus_oe, 1);
    chk("R1 bus_hold", bus_hold, 0);
    chk("R1 wake_ready", wake_ready, 0);
  endtask

  task automatic t_fields();
    logic [7:0] d;
    reg_write(1'b0, 8'h57);
    reg_read(1'b0, d); chk("R2 low bits masked", d, 8'h50);
    reg_write(1'b0, 8'hAF);
    reg_read(1'b0, d); chk("R2 ssby/code/ope", d, 8'hA8);
    reg_write(1'b0, 8'h08);
  endtask

  task automatic t_entry_gate();
    @(negedge clk); sleep_cmd = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0;
    chk("R6 sleep ignored without select", clk_en, 1);
    @(negedge clk); wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
    chk("R10 wake in run ignored", clk_en, 1);
    chk("R10 no ready from stray wake", wake_ready, 0);
  endtask

  task automatic t_code(input int code, input string req);
    int len, oel, rok;
    reg_write(1'b0, 8'(8'h88 | (code << 4)));
    enter_standby();
    chk({req, " standby entered"}, in_standby, 1);
    chk({req, " clk_en off"}, clk_en, 0);
    chk("R7 hold in standby", bus_hold, 1);
    chk("R7 oe kept in standby", bus_oe, 1);
    run_wake(1'b0, 1'b0, 8'h00, len, oel, rok);
    chk({req, " wait length"}, len, exp_len(code));
    chk("R8 ready pulse", rok, 1);
  endtask

  task automatic t_reserved();
    t_code(6, "R4");
  endtask

  task automatic t_prohibited();
    logic [7:0] d;
    t_code(7, "R5");
    reg_read(1'b1, d); chk("R5 flag set", d, 8'h01);
    reg_write(1'b0, 8'h88);
    reg_read(1'b1, d); chk("R5 flag sticky", d, 8'h01);
    reg_write(1'b1, 8'h01);
    reg_read(1'b1, d); chk("R5 flag cleared", d, 8'h00);
  endtask

  task automatic t_tristate();
    int len, oel, rok;
    reg_write(1'b0, 8'h90);
    enter_standby();
    chk("R7 oe off in standby", bus_oe, 0);
    chk("R7 no hold when tristate", bus_hold, 0);
    run_wake(1'b0, 1'b0, 8'h00, len, oel, rok);
    chk("R7 oe off through wait", oel, exp_len(1));
    chk("R8 oe back with ready", rok, 1);
  endtask

  task automatic t_disturb();
    int len, oel, rok;
    reg_write(1'b0, 8'hA8);
    enter_standby();
    run_wake(1'b1, 1'b0, 8'h00, len, oel, rok);
    chk("R9 extra events ignored", len, exp_len(2));
    chk("R9 back to running", clk_en, 1);
    chk("R9 not in standby", in_standby, 0);
  endtask

  task automatic t_capture();
    int len, oel, rok;
    reg_write(1'b0, 8'hB8);
    enter_standby();
    run_wake(1'b0, 1'b1, 8'h88, len, oel, rok);
    chk("R11 code latched at wake", len, exp_len(3));
    chk("R11 ready", rok, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_entry_gate();
    for (int c = 0; c < 6; c++) t_code(c, "R3");
    t_reserved();
    t_prohibited();
    t_tristate();
    t_disturb();
    t_capture();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule